// File: doc/BRIEF.md
# I2C Master Read Sequencer

This block is the master side of an I2C read from a 7-bit-addressed slave. Software drives the transfer one bus phase at a time. Each phase is launched by a one-cycle command strobe: Start, address send, byte receive, acknowledge or Stop. While its phase runs, a per-phase busy flag stays high. The flag drops by itself when the phase completes, and at that point the single interrupt flag is raised.

The block drives SCL and SDA as open-drain lines. An output high means "pull the line low", and an output low means "release the line". The resolved SDA level comes back on `sda_in`. Received bytes are assembled MSB first in a shift register and moved into a receive buffer. A buffer-full flag, an overflow flag, a stop-seen flag and the slave's address acknowledge are kept as status.

Each data bit is split into four quarters of `QDIV` system clocks. SCL is low in the first and last quarter and released in the middle two. SDA is sampled on the falling edge of SCL.

Top module: `i2c_rx_master`

## Requirements
- R1: After reset both lines are released, every busy flag is low, and `buf_full`, `ovf`, `irq`, `stop_seen`, `slave_nack` and `rx_data` are zero.
- R2: `cmd_start` runs a four-quarter Start phase. In quarter 0 both lines are released. In quarters 1 and 2 SDA is pulled low while SCL is released. In quarter 3 both are low, and both stay low afterwards.
- R3: `tx_wr` runs a nine-bit address phase. It sends `tx_addr[6]` down to `tx_addr[0]`, then a released R/W bit (read = 1), then releases SDA for the ninth bit. The ninth bit is sampled at its SCL fall, and `slave_nack` takes the sampled level (1 = no acknowledge). SCL stays low afterwards.
- R4: `cmd_recv` runs an eight-bit receive phase with SDA released throughout. One bit is shifted in, MSB first, at each falling SCL edge. SCL stays low afterwards.
- R5: When a receive phase ends with the buffer empty, the byte goes to `rx_data` and `buf_full` is set. `rx_rd` clears `buf_full`.
- R6: When a receive phase ends with `buf_full` still set, `ovf` is set and `rx_data` keeps the older byte. An `rx_rd` in the same cycle counts first. `clr_ovf` clears `ovf`.
- R7: `cmd_ack` drives `ack_bit` (captured at the command) for one bit time: 0 pulls SDA low, 1 releases it. Afterwards SCL is released and SDA is pulled low.
- R8: `cmd_stop` runs four quarters. In quarter 0 both lines are low. In quarter 1 SCL is released while SDA stays low. In quarters 2 and 3 both are released. At the end `stop_seen` is set and both lines stay released. A later accepted Start clears `stop_seen`.
- R9: `irq` is set at the end of every phase and cleared only by `clr_irq`; when both happen in the same cycle, the set wins.
- R10: Exactly one busy flag is high while a phase runs, and it drops at the phase end. Strobes arriving while any phase runs are ignored. When strobes coincide on an idle block, Start beats Stop, Stop beats address, address beats receive, and receive beats acknowledge.
- R11: A phase of N quarters ends N*`QDIV` clocks after the edge that accepts its strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start command strobe |
| cmd_stop | input | 1 | Stop command strobe |
| cmd_recv | input | 1 | Receive-byte command strobe |
| cmd_ack | input | 1 | Acknowledge command strobe |
| ack_bit | input | 1 | Acknowledge level to send (0 = ACK, 1 = NACK) |
| tx_wr | input | 1 | Address write strobe, launches the address phase |
| tx_addr | input | 7 | Slave address |
| rx_rd | input | 1 | Receive buffer read strobe |
| clr_irq | input | 1 | Clears the interrupt flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| sda_in | input | 1 | Resolved SDA line level |
| scl_low | output | 1 | Pull SCL low |
| sda_low | output | 1 | Pull SDA low |
| start_busy | output | 1 | Start phase running |
| addr_busy | output | 1 | Address phase running |
| recv_busy | output | 1 | Receive phase running |
| ack_busy | output | 1 | Acknowledge phase running |
| stop_busy | output | 1 | Stop phase running |
| rx_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| ovf | output | 1 | A byte arrived while the buffer was full |
| irq | output | 1 | Phase-end interrupt flag |
| stop_seen | output | 1 | A Stop phase has completed |
| slave_nack | output | 1 | Level sampled in the last address ninth bit |

## Verification
The properties assume that command strobes come from a software-facing register and last one clock. They also assume the slave never holds SCL low, so the line timing is fully set by the divider. The Start property also assumes a Start is issued only from a rest state with SDA released. The bench keeps to these assumptions: it issues Start only after reset, after a Stop or after a receive, and it drives SDA from a slave model that only ever pulls the line low. That model follows the falling SCL edges it observes and is reset alongside each command, so its bit count does not pick up the SCL drop that begins a receive after an acknowledge.

// File: rtl/i2c_rxm_pkg.sv
package i2c_rxm_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_START = 3'd1,
    PH_ADDR  = 3'd2,
    PH_RECV  = 3'd3,
    PH_ACK   = 3'd4,
    PH_STOP  = 3'd5
  } phase_t;

  localparam int QCNT_W = 6;

  // index of the final quarter of a phase
  function automatic logic [QCNT_W-1:0] last_quarter(input phase_t p);
    case (p)
      PH_ADDR: last_quarter = 6'd35;
      PH_RECV: last_quarter = 6'd31;
      default: last_quarter = 6'd3;
    endcase
  endfunction

endpackage

// File: rtl/i2c_rxm_qtick.sv
module i2c_rxm_qtick #(
  parameter int QDIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = run && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_rxm_seq.sv
module i2c_rxm_seq
  import i2c_rxm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       launch,
  input  phase_t     launch_ph,
  input  logic [6:0] addr_in,
  input  logic       ack_val,
  input  logic       tick,
  input  logic       sda_in,
  output phase_t     ph,
  output logic       done,
  output logic [7:0] byte_out,
  output logic       nack_out,
  output logic       scl_low,
  output logic       sda_low
);
  phase_t            ph_q, ph_d;
  logic [QCNT_W-1:0] cnt_q, cnt_d;
  logic [6:0]        addr_q, addr_d;
  logic              ackv_q, ackv_d;
  logic [7:0]        shreg_q, shreg_d;
  logic              nack_q, nack_d;
  logic              rest_scl_q, rest_scl_d;
  logic              rest_sda_q, rest_sda_d;
  logic [1:0]        q;
  logic [3:0]        b;
  logic              bit_low;

  assign q       = cnt_q[1:0];
  assign b       = cnt_q[5:2];
  assign bit_low = (q == 2'd0) || (q == 2'd3);
  assign done    = tick && (ph_q != PH_IDLE) && (cnt_q == last_quarter(ph_q));

  // next state
  always_comb begin
    ph_d       = ph_q;
    cnt_d      = cnt_q;
    addr_d     = addr_q;
    ackv_d     = ackv_q;
    shreg_d    = shreg_q;
    nack_d     = nack_q;
    rest_scl_d = rest_scl_q;
    rest_sda_d = rest_sda_q;
    if (launch) begin
      ph_d   = launch_ph;
      cnt_d  = '0;
      addr_d = addr_in;
      ackv_d = ack_val;
    end else if (tick && (ph_q != PH_IDLE)) begin
      if (ph_q == PH_RECV && q == 2'd2) shreg_d = {shreg_q[6:0], sda_in};
      if (ph_q == PH_ADDR && cnt_q == 6'd34) nack_d = sda_in;
      if (done) begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
        case (ph_q)
          PH_START: begin rest_scl_d = 1'b1; rest_sda_d = 1'b1; end
          PH_ACK:   begin rest_scl_d = 1'b0; rest_sda_d = 1'b1; end
          PH_STOP:  begin rest_scl_d = 1'b0; rest_sda_d = 1'b0; end
          default:  begin rest_scl_d = 1'b1; rest_sda_d = 1'b0; end
        endcase
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // line drive
  always_comb begin
    scl_low = rest_scl_q;
    sda_low = rest_sda_q;
    case (ph_q)
      PH_START: begin scl_low = (q == 2'd3); sda_low = (q != 2'd0); end
      PH_ADDR:  begin
        scl_low = bit_low;
        sda_low = (b < 4'd7) && !addr_q[3'd6 - b[2:0]];
      end
      PH_RECV:  begin scl_low = bit_low; sda_low = 1'b0; end
      PH_ACK:   begin scl_low = bit_low; sda_low = !ackv_q; end
      PH_STOP:  begin scl_low = (q == 2'd0); sda_low = (q < 2'd2); end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      cnt_q      <= '0;
      addr_q     <= '0;
      ackv_q     <= 1'b0;
      shreg_q    <= '0;
      nack_q     <= 1'b0;
      rest_scl_q <= 1'b0;
      rest_sda_q <= 1'b0;
    end else begin
      ph_q       <= ph_d;
      cnt_q      <= cnt_d;
      addr_q     <= addr_d;
      ackv_q     <= ackv_d;
      shreg_q    <= shreg_d;
      nack_q     <= nack_d;
      rest_scl_q <= rest_scl_d;
      rest_sda_q <= rest_sda_d;
    end
  end

  assign ph       = ph_q;
  assign byte_out = shreg_q;
  assign nack_out = nack_q;
endmodule

// File: rtl/i2c_rxm_status.sv
module i2c_rxm_status
  import i2c_rxm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  phase_t     done_ph,
  input  logic [7:0] byte_in,
  input  logic       nack_in,
  input  logic       rx_rd,
  input  logic       clr_irq,
  input  logic       clr_ovf,
  input  logic       start_acc,
  output logic [7:0] rx_data,
  output logic       buf_full,
  output logic       ovf,
  output logic       irq,
  output logic       stop_seen,
  output logic       slave_nack
);
  logic [7:0] data_q, data_d;
  logic       full_q, full_d, ovf_q, ovf_d, irq_q, irq_d;
  logic       stop_q, stop_d, nack_q, nack_d;
  logic       full_eff;

  always_comb begin
    full_eff = full_q && !rx_rd;
    data_d   = data_q;
    full_d   = full_eff;
    ovf_d    = ovf_q && !clr_ovf;
    irq_d    = irq_q && !clr_irq;
    stop_d   = stop_q && !start_acc;
    nack_d   = nack_q;
    if (done) begin
      irq_d = 1'b1;
      case (done_ph)
        PH_ADDR: nack_d = nack_in;
        PH_RECV: begin
          if (full_eff) ovf_d = 1'b1;
          else begin
            data_d = byte_in;
            full_d = 1'b1;
          end
        end
        PH_STOP: stop_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      irq_q  <= 1'b0;
      stop_q <= 1'b0;
      nack_q <= 1'b0;
    end else begin
      data_q <= data_d;
      full_q <= full_d;
      ovf_q  <= ovf_d;
      irq_q  <= irq_d;
      stop_q <= stop_d;
      nack_q <= nack_d;
    end
  end

  assign rx_data    = data_q;
  assign buf_full   = full_q;
  assign ovf        = ovf_q;
  assign irq        = irq_q;
  assign stop_seen  = stop_q;
  assign slave_nack = nack_q;
endmodule

// File: rtl/i2c_rx_master.sv
module i2c_rx_master
  import i2c_rxm_pkg::*;
#(
  parameter int QDIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_recv,
  input  logic       cmd_ack,
  input  logic       ack_bit,
  input  logic       tx_wr,
  input  logic [6:0] tx_addr,
  input  logic       rx_rd,
  input  logic       clr_irq,
  input  logic       clr_ovf,
  input  logic       sda_in,
  output logic       scl_low,
  output logic       sda_low,
  output logic       start_busy,
  output logic       addr_busy,
  output logic       recv_busy,
  output logic       ack_busy,
  output logic       stop_busy,
  output logic [7:0] rx_data,
  output logic       buf_full,
  output logic       ovf,
  output logic       irq,
  output logic       stop_seen,
  output logic       slave_nack
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  phase_t     ph, launch_ph;
  logic       launch, tick, done;
  logic [7:0] shift_byte;
  logic       nack_smp;

  // reset: asserted asynchronously, released after two clocks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // command acceptance with fixed priority, only when idle
  always_comb begin
    launch    = (ph == PH_IDLE) && (cmd_start || cmd_stop || tx_wr || cmd_recv || cmd_ack);
    launch_ph = PH_IDLE;
    if      (cmd_start) launch_ph = PH_START;
    else if (cmd_stop)  launch_ph = PH_STOP;
    else if (tx_wr)     launch_ph = PH_ADDR;
    else if (cmd_recv)  launch_ph = PH_RECV;
    else if (cmd_ack)   launch_ph = PH_ACK;
  end

  i2c_rxm_qtick #(.QDIV(QDIV)) u_qtick (
    .clk   (clk),
    .rst_n (rst_int_n),
    .run   (ph != PH_IDLE),
    .tick  (tick)
  );

  i2c_rxm_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .launch    (launch),
    .launch_ph (launch_ph),
    .addr_in   (tx_addr),
    .ack_val   (ack_bit),
    .tick      (tick),
    .sda_in    (sda_in),
    .ph        (ph),
    .done      (done),
    .byte_out  (shift_byte),
    .nack_out  (nack_smp),
    .scl_low   (scl_low),
    .sda_low   (sda_low)
  );

  i2c_rxm_status u_status (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .done       (done),
    .done_ph    (ph),
    .byte_in    (shift_byte),
    .nack_in    (nack_smp),
    .rx_rd      (rx_rd),
    .clr_irq    (clr_irq),
    .clr_ovf    (clr_ovf),
    .start_acc  (launch && (launch_ph == PH_START)),
    .rx_data    (rx_data),
    .buf_full   (buf_full),
    .ovf        (ovf),
    .irq        (irq),
    .stop_seen  (stop_seen),
    .slave_nack (slave_nack)
  );

  assign start_busy = (ph == PH_START);
  assign addr_busy  = (ph == PH_ADDR);
  assign recv_busy  = (ph == PH_RECV);
  assign ack_busy   = (ph == PH_ACK);
  assign stop_busy  = (ph == PH_STOP);
endmodule

// File: rtl/i2c_rx_master_chk.sv
module i2c_rx_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic       scl_low,
  input logic       sda_low,
  input logic       start_busy,
  input logic       addr_busy,
  input logic       recv_busy,
  input logic       ack_busy,
  input logic       stop_busy,
  input logic [7:0] rx_data,
  input logic       buf_full,
  input logic       ovf,
  input logic       irq,
  input logic       stop_seen
);
  p_busy_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_busy, addr_busy, recv_busy, ack_busy, stop_busy}));

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (recv_busy && cmd_start) |=> !start_busy);

  p_start_cond_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_busy && $rose(sda_low)) |-> !scl_low);

  p_recv_sda_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    recv_busy |-> !sda_low);

  p_full_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_full) |-> irq);

  p_no_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $stable(rx_data));

  p_stop_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_busy) |-> (stop_seen && !scl_low && !sda_low));

  p_irq_on_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(start_busy) || $fell(addr_busy) || $fell(recv_busy) ||
     $fell(ack_busy) || $fell(stop_busy)) |-> irq);
endmodule

bind i2c_rx_master i2c_rx_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_start  (cmd_start),
  .scl_low    (scl_low),
  .sda_low    (sda_low),
  .start_busy (start_busy),
  .addr_busy  (addr_busy),
  .recv_busy  (recv_busy),
  .ack_busy   (ack_busy),
  .stop_busy  (stop_busy),
  .rx_data    (rx_data),
  .buf_full   (buf_full),
  .ovf        (ovf),
  .irq        (irq),
  .stop_seen  (stop_seen)
);

// File: tb/test_i2c_rx_master.sv
module test_i2c_rx_master;
  localparam int CLK_PERIOD = 10;
  localparam int QDIV = 4;

  logic clk, rst_n;
  logic cmd_start, cmd_stop, cmd_recv, cmd_ack, ack_bit, tx_wr;
  logic [6:0] tx_addr;
  logic rx_rd, clr_irq, clr_ovf, sda_in;
  logic scl_low, sda_low, start_busy, addr_busy, recv_busy, ack_busy, stop_busy;
  logic [7:0] rx_data;
  logic buf_full, ovf, irq, stop_seen, slave_nack;

  i2c_rx_master #(.QDIV(QDIV)) i_i2c_rx_master (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .cmd_recv(cmd_recv), .cmd_ack(cmd_ack), .ack_bit(ack_bit), .tx_wr(tx_wr),
    .tx_addr(tx_addr), .rx_rd(rx_rd), .clr_irq(clr_irq), .clr_ovf(clr_ovf),
    .sda_in(sda_in), .scl_low(scl_low), .sda_low(sda_low),
    .start_busy(start_busy), .addr_busy(addr_busy), .recv_busy(recv_busy),
    .ack_busy(ack_busy), .stop_busy(stop_busy), .rx_data(rx_data),
    .buf_full(buf_full), .ovf(ovf), .irq(irq), .stop_seen(stop_seen),
    .slave_nack(slave_nack)
  );

  int checks = 0, errors = 0;
  bit fin = 0;

  initial begin clk = 0; forever #(CLK_PERIOD/2) clk = ~clk; end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run;
    if (!fin) begin
      fin = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // ---------------- slave model ----------------
  int         sl_mode = 0;   // 0 silent, 1 address ack, 2 send byte
  bit         sl_ack_on = 1;
  logic [7:0] sl_byte = 8'h00;
  logic       sl_clr = 0;
  int         sl_falls;
  logic       sl_prev;
  logic       sl_low;

  always @(posedge clk) begin
    if (sl_clr) begin
      sl_falls <= 0;
      sl_prev  <= 1'b1;
    end else begin
      if (scl_low && !sl_prev) sl_falls <= sl_falls + 1;
      sl_prev <= scl_low;
    end
  end

  always_comb begin
    sl_low = 1'b0;
    if (sl_mode == 1) sl_low = (sl_falls == 8) && sl_ack_on;
    else if (sl_mode == 2 && sl_falls >= 0 && sl_falls < 8)
      sl_low = !sl_byte[7 - sl_falls];
  end
  assign sda_in = !(sda_low || sl_low);

  // ---------------- reference model ----------------
  int         m_ph;          // 0 idle 1 start 2 addr 3 recv 4 ack 5 stop
  int         m_e;
  logic [6:0] m_addr;
  bit         m_ackv, m_irq, m_full, m_ovf, m_stop, m_nack, m_rscl, m_rsda;
  logic [7:0] m_rx;

  function automatic int nq(input int p);
    if (p == 2) return 36;
    if (p == 3) return 32;
    return 4;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_e = 0; m_addr = 0; m_ackv = 0; m_irq = 0; m_full = 0;
      m_ovf = 0; m_stop = 0; m_nack = 0; m_rscl = 0; m_rsda = 0; m_rx = 0;
    end else begin
      if (rx_rd)   m_full = 0;
      if (clr_ovf) m_ovf = 0;
      if (clr_irq) m_irq = 0;
      if (m_ph != 0) begin
        m_e++;
        if (m_e == nq(m_ph) * QDIV) begin
          m_irq = 1;
          case (m_ph)
            1: begin m_rscl = 1; m_rsda = 1; end
            2: begin m_rscl = 1; m_rsda = 0; m_nack = !sl_ack_on; end
            3: begin
              m_rscl = 1; m_rsda = 0;
              if (m_full) m_ovf = 1;
              else begin m_rx = sl_byte; m_full = 1; end
            end
            4: begin m_rscl = 0; m_rsda = 1; end
            default: begin m_rscl = 0; m_rsda = 0; m_stop = 1; end
          endcase
          m_ph = 0;
        end
      end else begin
        m_e = 0;
        if (cmd_start)     begin m_ph = 1; m_stop = 0; end
        else if (cmd_stop) m_ph = 5;
        else if (tx_wr)    begin m_ph = 2; m_addr = tx_addr; end
        else if (cmd_recv) m_ph = 3;
        else if (cmd_ack)  begin m_ph = 4; m_ackv = ack_bit; end
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      int k, q, b;
      bit es, ed;
      string lt;
      es = m_rscl; ed = m_rsda; lt = "R1";
      k = m_e / QDIV; q = k % 4; b = k / 4;
      case (m_ph)
        1: begin lt = "R2"; es = (q == 3); ed = (q != 0); end
        2: begin lt = "R3"; es = (q == 0 || q == 3); ed = (b < 7) ? !m_addr[6 - b] : 1'b0; end
        3: begin lt = "R4"; es = (q == 0 || q == 3); ed = 0; end
        4: begin lt = "R7"; es = (q == 0 || q == 3); ed = !m_ackv; end
        5: begin lt = "R8"; es = (q == 0); ed = (q < 2); end
        default: ;
      endcase
      chk(lt, "scl_low", scl_low, es);
      chk(lt, "sda_low", sda_low, ed);
      chk("R10 R11", "busy flags",
          {start_busy, addr_busy, recv_busy, ack_busy, stop_busy},
          {m_ph == 1, m_ph == 2, m_ph == 3, m_ph == 4, m_ph == 5});
      chk("R9", "irq", irq, m_irq);
      chk("R5", "buf_full", buf_full, m_full);
      chk("R5", "rx_data", rx_data, m_rx);
      chk("R6", "ovf", ovf, m_ovf);
      chk("R8", "stop_seen", stop_seen, m_stop);
      chk("R3", "slave_nack", slave_nack, m_nack);
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit s, input bit p, input bit a, input bit r, input bit k);
    @(negedge clk);
    cmd_start = s; cmd_stop = p; tx_wr = a; cmd_recv = r; cmd_ack = k; sl_clr = 1;
    @(negedge clk);
    cmd_start = 0; cmd_stop = 0; tx_wr = 0; cmd_recv = 0; cmd_ack = 0;
    @(negedge clk);
    sl_clr = 0;
  endtask

  task automatic wait_idle;
    while (m_ph != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_clear(input bit rd, input bit ci, input bit co);
    @(negedge clk);
    rx_rd = rd; clr_irq = ci; clr_ovf = co;
    @(negedge clk);
    rx_rd = 0; clr_irq = 0; clr_ovf = 0;
  endtask

  initial begin
    rst_n = 0; cmd_start = 0; cmd_stop = 0; cmd_recv = 0; cmd_ack = 0;
    ack_bit = 0; tx_wr = 0; tx_addr = 7'h00; rx_rd = 0; clr_irq = 0; clr_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset scl_low", scl_low, 0);
    chk("R1", "reset sda_low", sda_low, 0);
    chk("R1", "reset flags", {buf_full, ovf, irq, stop_seen, slave_nack}, 0);
    chk("R1", "reset rx_data", rx_data, 0);

    // R2 start
    issue(1, 0, 0, 0, 0);
    wait_idle();
    chk("R2", "rest after start", {scl_low, sda_low}, 2'b11);
    chk("R9", "irq after start", irq, 1);
    pulse_clear(0, 1, 0);
    chk("R9", "irq cleared", irq, 0);

    // R3 address with acknowledge
    sl_mode = 1; sl_ack_on = 1; tx_addr = 7'h52;
    issue(0, 0, 1, 0, 0);
    wait_idle();
    chk("R3", "slave acked", slave_nack, 0);

    // R4 R5 receive into empty buffer
    sl_mode = 2; sl_byte = 8'h5C;
    issue(0, 0, 0, 1, 0);
    wait_idle();
    chk("R5", "rx_data first byte", rx_data, 8'h5C);
    chk("R5", "buf_full set", buf_full, 1);

    // R7 acknowledge with 0
    sl_mode = 0; ack_bit = 0;
    issue(0, 0, 0, 0, 1);
    wait_idle();
    chk("R7", "rest after ack", {scl_low, sda_low}, 2'b01);

    // R6 second byte while full, R10 stop ignored mid-receive
    sl_mode = 2; sl_byte = 8'h3A;
    issue(0, 0, 0, 1, 0);
    repeat (20) @(negedge clk);
    cmd_stop = 1;
    @(negedge clk);
    cmd_stop = 0;
    chk("R10", "stop ignored while busy", {stop_busy, recv_busy}, 2'b01);
    wait_idle();
    chk("R6", "ovf set", ovf, 1);
    chk("R6", "rx_data kept", rx_data, 8'h5C);
    chk("R10", "no stop ran", stop_seen, 0);
    pulse_clear(1, 1, 1);
    chk("R5", "read clears full", buf_full, 0);
    chk("R6", "ovf cleared", ovf, 0);

    // R7 negative acknowledge, then R8 stop
    sl_mode = 0; ack_bit = 1;
    issue(0, 0, 0, 0, 1);
    wait_idle();
    issue(0, 1, 0, 0, 0);
    wait_idle();
    chk("R8", "stop_seen", stop_seen, 1);
    chk("R8", "lines released", {scl_low, sda_low}, 2'b00);

    // R10 priority: start beats stop; R8 stop_seen cleared by start
    issue(1, 1, 0, 0, 0);
    wait_idle();
    chk("R10", "start won", {scl_low, sda_low}, 2'b11);
    chk("R8", "stop_seen cleared", stop_seen, 0);

    // R3 address without acknowledge
    sl_mode = 1; sl_ack_on = 0; tx_addr = 7'h48;
    issue(0, 0, 1, 0, 0);
    wait_idle();
    chk("R3", "slave nack", slave_nack, 1);

    // R4 another byte into empty buffer
    sl_mode = 2; sl_ack_on = 1; sl_byte = 8'h81;
    issue(0, 0, 0, 1, 0);
    wait_idle();
    chk("R4", "rx_data msb first", rx_data, 8'h81);
    sl_mode = 0;
    issue(0, 1, 0, 0, 0);
    wait_idle();
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end
endmodule